// File: doc/BRIEF.md
# Thread Interrupt Context Register Window

This block is the per-thread register file for interrupt priority management, reached through a memory-mapped window. The window is split into four privilege pages, selected by address bits [17:16]. Page 0 is the hardware view and the most privileged. Page 1 is the hypervisor view, page 2 the operating-system view and page 3 the user view.

Behind every page sits the same 64-byte array, made of four 16-byte rings: user at 0x00, OS at 0x10, pool at 0x20 and physical at 0x30. Each page has its own read and write permission for every byte of the array. A load or store in the lower half of a page works on the raw bytes, after the permission filter for that page. The upper half of a page (address bit 11 set) is kept for side-effect operations, which are matched exactly.

One such operation exists in the lower half: a one-byte store that sets the OS priority register and clamps it. The OS acknowledge load sits in the upper half and returns zero. Illegal accesses raise a one-cycle error pulse.

Top module: `tctx_mmio`

## Requirements
- R1: After reset every byte reads as zero except OS-ring bytes 0x13, 0x14 and 0x16, which hold 0xFF; `rspRdata` is zero and `rspErr` is low.
- R2: The page number is address bits [17:16]. A raw load returns zero in every byte lane whose array byte has no read permission on that page. The permission codes are 0 none, 1 write only, 2 read only and 3 read/write.
- R3: A raw store changes only the bytes that have write permission on the page used. Data is big-endian: the byte at the lowest offset travels in the most significant byte lane of the access, and a 4-byte access uses data bits [31:0].
- R4: A raw access is legal only if all of these hold: its size is 4 or 8, its ring (address bits [5:4]) is not the user ring, its offset plus size does not pass byte 64, and at least one of its bytes is permitted. Any other raw access raises the error and leaves the array unchanged.
- R5: An illegal load returns all ones on `rspRdata`.
- R6: An access with address bit 11 set never takes the raw path. If its address bits [11:0], size and direction match no defined operation, it is an error.
- R7: A 1-byte store with address bits [11:0] = 0x011 from page 0, 1 or 2 writes byte 0x11 with `reqWdata[7:0]`. Values 0 to 7 are kept and larger values become 0xFF. From page 3 the store is not matched.
- R8: A 2-byte load with address bits [11:0] = 0x810 from page 0, 1 or 2 returns zero without error. From page 3 it is an error.
- R9: `rspRdata` and `rspErr` are registered, so they answer in the cycle after the request. `rspErr` is a one-cycle pulse. `rspRdata` holds its value across stores and idle cycles.
- R10: An access of size 1 or 2 that matches no defined operation falls to the raw path and is rejected as an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | 18 | Window address: page in [17:16], special-op flag in bit 11, byte offset in [5:0] |
| reqSize | input | 4 | Access size in bytes, 1 to 8 |
| reqWdata | input | 64 | Store data, right-aligned, big-endian |
| rspRdata | output | 64 | Load data, registered |
| rspErr | output | 1 | Illegal-access pulse, registered |

## Verification
The bench targets the places where a careless decoder goes wrong. The first is a raw access aimed at the user ring or sized below four bytes; a decoder that lets these through lets software corrupt state. The second is an upper-half access that misses every defined operation; a decoder that falls back to raw data here returns live register bytes instead of all ones. The third is the priority store at the clamp boundary of 7 and 8 and from the user page; an off-by-one comparison or a wrong page compare shows up as a wrong stored value. The bench also reads the same bytes through different pages, to expose a permission map indexed by the wrong page or byte, and it checks an access that runs past byte 63, which a wrapping decoder would wrongly accept.

// File: rtl/tctx_pkg.sv
package tctx_pkg;
  localparam int ADDR_W     = 18;
  localparam int DATA_W     = 64;
  localparam int LANES      = DATA_W / 8;
  localparam int RING_BYTES = 16;
  localparam int RING_COUNT = 4;
  localparam int ARR_BYTES  = RING_BYTES * RING_COUNT;
  localparam int OFF_W      = $clog2(ARR_BYTES);
  localparam int SIZE_W     = 4;
  localparam int MAX_PRIO   = 7;
  localparam int OS_BASE    = RING_BYTES;
  localparam int PRIO_IDX   = OS_BASE + 1;
  localparam int LSMFB_IDX  = OS_BASE + 3;
  localparam int ACKC_IDX   = OS_BASE + 4;
  localparam int AGE_IDX    = OS_BASE + 6;
  localparam logic [11:0] PRIO_OP = 12'h011;
  localparam logic [11:0] ACK_OP  = 12'h810;
  localparam logic [1:0]  OS_PAGE = 2'd2;

  typedef struct packed {
    logic              rawWr;
    logic              rawRd;
    logic              prioWr;
    logic              ackRd;
    logic              errRd;
    logic              errAny;
    logic [LANES-1:0]  laneMask;
    logic [OFF_W-1:0]  baseOff;
    logic [SIZE_W-1:0] size;
  } tctx_strb_t;

  // One hex digit per byte, byte 0 leftmost; low two bits are the permission.
  function automatic logic [63:0] permRow(logic [1:0] page, logic [1:0] ring);
    case ({page, ring})
      4'b00_00, 4'b01_00, 4'b10_00: permRow = 64'h3000_0000_3333_0000;
      4'b00_01, 4'b01_01:           permRow = 64'h3333_3303_3333_0000;
      4'b00_10:                     permRow = 64'h0033_0000_3333_0000;
      4'b00_11:                     permRow = 64'h3333_0303_3003_3330;
      4'b01_10:                     permRow = 64'h0033_0000_0333_0000;
      4'b01_11:                     permRow = 64'h3333_0303_3003_0000;
      4'b10_01:                     permRow = 64'h2322_2202_0000_0000;
      4'b11_00:                     permRow = 64'h3000_0000_0000_0000;
      default:                      permRow = 64'h0;
    endcase
  endfunction

  function automatic logic [1:0] permByte(logic [1:0] page, logic [OFF_W-1:0] idx);
    logic [63:0] row;
    row = permRow(page, idx[5:4]);
    return row[60 - 4 * int'(idx[3:0]) +: 2];
  endfunction
endpackage

// File: rtl/tctx_ctrl.sv
module tctx_ctrl
  import tctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  output tctx_strb_t        strb
);
  logic [1:0]       page;
  logic [1:0]       ring;
  logic [OFF_W-1:0] off;
  logic [11:0]      opOff;
  logic             inRange, sizeOk, prioHit, ackHit, rawOk;
  logic [LANES-1:0] laneMask;

  assign page  = reqAddr[17:16];
  assign ring  = reqAddr[5:4];
  assign off   = reqAddr[OFF_W-1:0];
  assign opOff = reqAddr[11:0];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      logic [1:0] perm;
      perm = permByte(page, off + OFF_W'(i));
      laneMask[i] = (SIZE_W'(i) < reqSize) &&
                    ((int'(off) + i) < ARR_BYTES) &&
                    (reqWrite ? perm[0] : perm[1]);
    end
  end

  assign inRange = (int'(off) + int'(reqSize)) <= ARR_BYTES;
  assign sizeOk  = (reqSize == 4'd4) || (reqSize == 4'd8);
  assign prioHit = reqWrite && (opOff == PRIO_OP) && (reqSize == 4'd1) && (page <= OS_PAGE);
  assign ackHit  = !reqWrite && (opOff == ACK_OP) && (reqSize == 4'd2) && (page <= OS_PAGE);
  assign rawOk   = sizeOk && (ring != 2'd0) && inRange && (|laneMask);

  always_comb begin
    strb          = '0;
    strb.laneMask = laneMask;
    strb.baseOff  = off;
    strb.size     = reqSize;
    if (reqValid) begin
      if (reqAddr[11]) begin
        if (ackHit) strb.ackRd  = 1'b1;
        else        strb.errAny = 1'b1;
      end else if (prioHit) begin
        strb.prioWr = 1'b1;
      end else if (rawOk) begin
        strb.rawWr = reqWrite;
        strb.rawRd = !reqWrite;
      end else begin
        strb.errAny = 1'b1;
      end
    end
    strb.errRd = strb.errAny && !reqWrite;
  end

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.rawWr, strb.rawRd, strb.prioWr, strb.ackRd, strb.errAny})); // R6
  AST_UPPER_NO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqAddr[11]) |-> !(strb.rawWr || strb.rawRd || strb.prioWr)); // R6
  AST_RAW_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.rawWr || strb.rawRd) |-> ((reqSize == 4'd4 || reqSize == 4'd8) && reqAddr[5:4] != 2'd0)); // R4
endmodule

// File: rtl/tctx_regs.sv
module tctx_regs
  import tctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tctx_strb_t        strb,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);
  logic [7:0]        regFile [ARR_BYTES];
  logic [7:0]        laneByte [LANES];
  logic [DATA_W-1:0] rdNext;
  logic [7:0]        prioVal;

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < LANES; i++) begin
      int sh;
      sh = 8 * (int'(strb.size) - 1 - i);
      laneByte[i] = 8'h00;
      if (sh >= 0) begin
        laneByte[i] = reqWdata[sh +: 8];
        if (strb.laneMask[i]) rdNext[sh +: 8] = regFile[strb.baseOff + OFF_W'(i)];
      end
    end
  end

  assign prioVal = (reqWdata[7:0] > 8'(MAX_PRIO)) ? 8'hFF : reqWdata[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_BYTES; i++)
        regFile[i] <= (i == LSMFB_IDX || i == ACKC_IDX || i == AGE_IDX) ? 8'hFF : 8'h00;
    end else begin
      if (strb.rawWr) begin
        for (int i = 0; i < LANES; i++)
          if (strb.laneMask[i]) regFile[strb.baseOff + OFF_W'(i)] <= laneByte[i];
      end
      if (strb.prioWr) regFile[PRIO_IDX] <= prioVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspRdata <= '0;
      rspErr   <= 1'b0;
    end else begin
      rspErr <= strb.errAny;
      if (strb.rawRd)      rspRdata <= rdNext;
      else if (strb.ackRd) rspRdata <= '0;
      else if (strb.errRd) rspRdata <= '1;
    end
  end

  AST_ERR_LOAD_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    strb.errRd |=> (rspRdata == '1 && rspErr)); // R5
  AST_ACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    strb.ackRd |=> (rspRdata == '0 && !rspErr)); // R8
  AST_PRIO_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    strb.prioWr |=> (regFile[PRIO_IDX] <= 8'(MAX_PRIO) || regFile[PRIO_IDX] == 8'hFF)); // R7
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.rawRd || strb.ackRd || strb.errRd) |=> $stable(rspRdata)); // R9

  for (genvar g = 0; g < RING_BYTES; g++) begin : gUserRing
    AST_USER_RING_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(regFile[g])); // R4
  end
endmodule

// File: rtl/tctx_mmio.sv
module tctx_mmio
  import tctx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SIZE_W-1:0] reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr
);
  tctx_strb_t strb;

  tctx_ctrl uCtrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .strb     (strb)
  );

  tctx_regs uRegs (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .reqWdata (reqWdata),
    .rspRdata (rspRdata),
    .rspErr   (rspErr)
  );
endmodule

// File: tb/tb_tctx_mmio.sv
module tb_tctx_mmio;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [3:0]  reqSize = '0;
  logic [63:0] reqWdata = '0;
  logic [63:0] rspRdata;
  logic        rspErr;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  tctx_mmio dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspRdata(rspRdata), .rspErr(rspErr)
  );

  typedef struct packed {
    logic        wr;
    logic [17:0] addr;
    logic [3:0]  size;
    logic [63:0] wdata;
    logic [63:0] expData;
    logic        expErr;
    logic [3:0]  req;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam int NV = 33;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 18'h00010, 4'd8, 64'h0, 64'h0000_00FF_FF00_0000, 1'b0, 4'd1},  // R1 defaults
    '{1'b0, 18'h30010, 4'd4, 64'h0, ONES,                    1'b1, 4'd2},  // R2 user page sees no OS bytes
    '{1'b1, 18'h00030, 4'd8, 64'h1122_3344_5566_7788, 64'h0, 1'b0, 4'd3},  // R3
    '{1'b0, 18'h00030, 4'd8, 64'h0, 64'h1122_3344_0066_0088, 1'b0, 4'd3},  // R3 masked bytes untouched
    '{1'b1, 18'h10038, 4'd4, 64'hAABB_CCDD, 64'h0,           1'b0, 4'd3},  // R3
    '{1'b0, 18'h00038, 4'd4, 64'h0, 64'hAA00_00DD,           1'b0, 4'd3},  // R3
    '{1'b1, 18'h20010, 4'd4, 64'h0102_0304, 64'h0,           1'b0, 4'd2},  // R2 OS page writes one byte
    '{1'b0, 18'h00010, 4'd4, 64'h0, 64'h0002_00FF,           1'b0, 4'd2},  // R2
    '{1'b1, 18'h00028, 4'd4, 64'h5A5A_5A5A, 64'h0,           1'b0, 4'd3},  // R3
    '{1'b1, 18'h20028, 4'd4, 64'h0, 64'h0,                   1'b1, 4'd4},  // R4 empty mask
    '{1'b0, 18'h00028, 4'd4, 64'h0, 64'h5A5A_5A5A,           1'b0, 4'd4},  // R4 unchanged
    '{1'b0, 18'h10028, 4'd4, 64'h0, 64'h005A_5A5A,           1'b0, 4'd2},  // R2 hypervisor view
    '{1'b1, 18'h00000, 4'd4, 64'h1234_5678, 64'h0,           1'b1, 4'd4},  // R4 user ring store
    '{1'b0, 18'h00008, 4'd4, 64'h0, ONES,                    1'b1, 4'd4},  // R4 user ring load
    '{1'b0, 18'h0003C, 4'd8, 64'h0, ONES,                    1'b1, 4'd4},  // R4 past end
    '{1'b1, 18'h00020, 4'd2, 64'h1234, 64'h0,                1'b1, 4'd10}, // R10
    '{1'b0, 18'h00013, 4'd1, 64'h0, ONES,                    1'b1, 4'd10}, // R10
    '{1'b1, 18'h20011, 4'd1, 64'h05, 64'h0,                  1'b0, 4'd7},  // R7
    '{1'b0, 18'h00010, 4'd4, 64'h0, 64'h0005_00FF,           1'b0, 4'd7},  // R7
    '{1'b1, 18'h20011, 4'd1, 64'h08, 64'h0,                  1'b0, 4'd7},  // R7 clamp
    '{1'b0, 18'h00010, 4'd4, 64'h0, 64'h00FF_00FF,           1'b0, 4'd7},  // R7
    '{1'b1, 18'h00011, 4'd1, 64'h07, 64'h0,                  1'b0, 4'd7},  // R7 boundary kept
    '{1'b0, 18'h00010, 4'd4, 64'h0, 64'h0007_00FF,           1'b0, 4'd7},  // R7
    '{1'b1, 18'h30011, 4'd1, 64'h03, 64'h0,                  1'b1, 4'd7},  // R7 user page
    '{1'b1, 18'h20051, 4'd1, 64'h02, 64'h0,                  1'b1, 4'd10}, // R10
    '{1'b0, 18'h00010, 4'd4, 64'h0, 64'h0007_00FF,           1'b0, 4'd7},  // R7 unchanged
    '{1'b0, 18'h20810, 4'd2, 64'h0, 64'h0,                   1'b0, 4'd8},  // R8
    '{1'b0, 18'h00810, 4'd2, 64'h0, 64'h0,                   1'b0, 4'd8},  // R8
    '{1'b0, 18'h30810, 4'd2, 64'h0, ONES,                    1'b1, 4'd8},  // R8
    '{1'b0, 18'h00810, 4'd4, 64'h0, ONES,                    1'b1, 4'd6},  // R6 no fallback
    '{1'b1, 18'h00830, 4'd8, ONES, 64'h0,                    1'b1, 4'd6},  // R6
    '{1'b0, 18'h00030, 4'd8, 64'h0, 64'h1122_3344_0066_0088, 1'b0, 4'd6},  // R6 unchanged
    '{1'b1, 18'h20810, 4'd2, 64'h0, 64'h0,                   1'b1, 4'd6}   // R6
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [17:0] addr, input logic [3:0] size,
                        input logic [63:0] wdata);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqSize = size; reqWdata = wdata;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(rspRdata == 64'h0, "R1 rdata after reset", rspRdata, 64'h0);
    check(rspErr == 1'b0, "R1 err after reset", 64'(rspErr), 64'h0);

    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[v].req, v);
      access(VECS[v].wr, VECS[v].addr, VECS[v].size, VECS[v].wdata);
      check(rspErr == VECS[v].expErr, {tag, " err"}, 64'(rspErr), 64'(VECS[v].expErr));
      if (!VECS[v].wr)
        check(rspRdata == VECS[v].expData, {tag, " data"}, rspRdata, VECS[v].expData);
    end

    // R9: error is a pulse and load data holds through idle and stores
    access(1'b0, 18'h00008, 4'd4, 64'h0);
    @(negedge clk);
    check(rspErr == 1'b0, "R9 err pulse one cycle", 64'(rspErr), 64'h0);
    check(rspRdata == ONES, "R9 rdata holds idle", rspRdata, ONES);
    access(1'b1, 18'h00028, 4'd4, 64'h0101_0101);
    check(rspRdata == ONES, "R9 rdata holds on store", rspRdata, ONES);

    // R1: reset mid-run restores defaults
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    check(rspRdata == 64'h0, "R1 rdata cleared", rspRdata, 64'h0);
    access(1'b0, 18'h00030, 4'd8, 64'h0);
    check(rspRdata == 64'h0, "R1 phys ring cleared", rspRdata, 64'h0);
    access(1'b0, 18'h00010, 4'd8, 64'h0);
    check(rspRdata == 64'h0000_00FF_FF00_0000, "R1 OS defaults", rspRdata, 64'h0000_00FF_FF00_0000);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule